// File: doc/BRIEF.md
# Configurable Serial Audio Receiver

This block turns a serial audio stream into parallel words. The external bit clock, the frame sync and the data line all pass through a synchronizer into the system clock domain. The selected edge of the synchronized bit clock becomes a one-cycle sample strobe. At each strobe the receiver looks for the start of a frame sync, skips the programmed data delay, shifts the data bits in most significant bit first, and places each finished word right-aligned in a 32-bit output register. A one-cycle ready pulse marks each finished word.

Inputs set the word length, one or two words per frame, a data delay of zero or one bit clock, the sampling edge and the frame-sync polarity. A separate input decides what happens to a frame sync that arrives while a frame is still being received: it is either ignored, or it restarts the frame and sets a sticky error flag. While the enable input is low the receiver stays idle and ignores all serial activity.

Top module: `srx_receiver`

## Requirements
- R1: `cfg_wlen` picks the word size: code 0 gives 8 bits, 1 gives 12, 2 gives 16, 3 gives 20, 4 gives 24, and 5, 6 and 7 give 32. The first bit received is the word's most significant bit. `rx_word` holds the word right-aligned, and its upper bits are zero.
- R2: `rx_ready` goes high for exactly one system clock cycle for each finished word. In that same cycle `rx_word` carries the new word.
- R3: A frame starts at the first sample strobe where the frame sync is active after being inactive at the strobe before. With `cfg_delay`=0 the data bit taken at that strobe is the word's most significant bit. With `cfg_delay`=1 that bit is skipped and the most significant bit is taken at the next strobe.
- R4: With `cfg_rise_edge`=1 the data and the frame sync are sampled on rising edges of `ser_clk`. With `cfg_rise_edge`=0 they are sampled on falling edges.
- R5: With `cfg_fs_low`=0 the frame sync is active high. With `cfg_fs_low`=1 it is active low.
- R6: With `cfg_two_words`=1 a frame holds two words of the same length, sent back to back, and both are reported. With `cfg_two_words`=0 a frame holds one word. After its last word the receiver waits for the next frame sync.
- R7: With `cfg_ign_fs`=1, a frame sync that starts while a frame is in progress has no effect. The words of the current frame come out unchanged, and `sync_err` stays low.
- R8: With `cfg_ign_fs`=0, a frame sync that starts while a frame is in progress sets `sync_err` and throws away the partial word. A new frame begins from that strobe. `sync_err` stays set until `rx_en` goes low.
- R9: While `rx_en` is low no words are produced, `rx_word` keeps its last value and `sync_err` is cleared.
- R10: After reset `rx_word` is zero, and `rx_ready` and `sync_err` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_en | input | 1 | Receiver enable; low holds the receiver idle |
| ser_clk | input | 1 | External bit clock |
| ser_fs | input | 1 | External frame sync |
| ser_dat | input | 1 | Serial data line |
| cfg_wlen | input | 3 | Word length code |
| cfg_two_words | input | 1 | One (0) or two (1) words per frame |
| cfg_delay | input | 1 | Data delay after frame sync, 0 or 1 bit |
| cfg_rise_edge | input | 1 | 1: sample on rising bit-clock edge, 0: falling |
| cfg_fs_low | input | 1 | 1: frame sync active low |
| cfg_ign_fs | input | 1 | 1: ignore frame syncs inside a frame |
| rx_word | output | 32 | Last received word, right-aligned |
| rx_ready | output | 1 | One-cycle pulse per finished word |
| sync_err | output | 1 | Sticky flag for a frame sync that arrived mid-frame |

## Verification
The hardest case to reach is a frame sync that lands partway through a word. The bench drives its own bit-level frames, so it can place a second frame-sync pulse in any chosen slot of a running frame. It then checks the result under both settings of the ignore option: with the option on, the original words must come out unchanged; with it off, only the words of the restarted frame may appear. Random frames vary the word length, the delay, the edge, the polarity and the frame length together with random data. The upper data bits of each random word are set beyond the chosen word length, so a wrong bit count shows up in the output value.

// File: rtl/srx_pkg.sv
package srx_pkg;
  localparam int SRX_MAX_BITS = 32;

  // Word length code to bit count; codes above 4 select the full 32 bits.
  function automatic logic [5:0] srx_wbits(input logic [2:0] code);
    case (code)
      3'd0:    srx_wbits = 6'd8;
      3'd1:    srx_wbits = 6'd12;
      3'd2:    srx_wbits = 6'd16;
      3'd3:    srx_wbits = 6'd20;
      3'd4:    srx_wbits = 6'd24;
      default: srx_wbits = 6'd32;
    endcase
  endfunction
endpackage

// File: rtl/srx_sampler.sv
module srx_sampler #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ser_clk,
  input  logic ser_fs,
  input  logic ser_dat,
  input  logic cfg_rise_edge,
  input  logic cfg_fs_low,
  output logic bit_stb,
  output logic fs_lvl,
  output logic dat_bit
);
  localparam int TOP = STAGES - 1;

  logic [TOP:0] ck_q, fs_q, dt_q;
  logic [TOP:0] ck_d, fs_d, dt_d;
  logic         ck_last_q;
  logic         rise, fall;

  generate
    if (STAGES == 1) begin : g_one
      always_comb begin
        ck_d = ser_clk;
        fs_d = ser_fs;
        dt_d = ser_dat;
      end
    end else begin : g_many
      always_comb begin
        ck_d = {ck_q[TOP-1:0], ser_clk};
        fs_d = {fs_q[TOP-1:0], ser_fs};
        dt_d = {dt_q[TOP-1:0], ser_dat};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ck_q      <= '0;
      fs_q      <= '0;
      dt_q      <= '0;
      ck_last_q <= 1'b0;
    end else begin
      ck_q      <= ck_d;
      fs_q      <= fs_d;
      dt_q      <= dt_d;
      ck_last_q <= ck_q[TOP];
    end
  end

  assign rise    = ck_q[TOP] & ~ck_last_q;
  assign fall    = ~ck_q[TOP] & ck_last_q;
  assign bit_stb = cfg_rise_edge ? rise : fall;
  assign fs_lvl  = fs_q[TOP] ^ cfg_fs_low;
  assign dat_bit = dt_q[TOP];
endmodule

// File: rtl/srx_shifter.sv
module srx_shifter
  import srx_pkg::*;
#(
  parameter int DATA_W = SRX_MAX_BITS
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              bit_stb,
  input  logic              fs_lvl,
  input  logic              dat_bit,
  input  logic [2:0]        cfg_wlen,
  input  logic              cfg_two_words,
  input  logic              cfg_delay,
  input  logic              cfg_ign_fs,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_ready,
  output logic              sync_err
);
  localparam int CNT_W = $clog2(DATA_W + 1);

  logic              active_q, active_d;
  logic              idx_q, idx_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [DATA_W-1:0] sh_q, sh_d;
  logic              fs_prev_q, fs_prev_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              rdy_q, rdy_d;
  logic              err_q, err_d;

  logic [CNT_W-1:0]  wbits;
  logic              fs_start, restart, take;
  logic [DATA_W-1:0] base_sh, new_sh;
  logic [CNT_W-1:0]  base_cnt;

  assign wbits    = CNT_W'(srx_wbits(cfg_wlen));
  assign fs_start = bit_stb & fs_lvl & ~fs_prev_q;
  assign restart  = fs_start & (~active_q | ~cfg_ign_fs);
  assign take     = bit_stb & ((restart & ~cfg_delay) | (~restart & active_q));
  assign base_sh  = restart ? '0 : sh_q;
  assign base_cnt = restart ? '0 : cnt_q;
  assign new_sh   = {base_sh[DATA_W-2:0], dat_bit};

  always_comb begin
    active_d  = active_q;
    idx_d     = idx_q;
    cnt_d     = cnt_q;
    sh_d      = sh_q;
    fs_prev_d = fs_prev_q;
    word_d    = word_q;
    rdy_d     = 1'b0;
    err_d     = err_q;
    if (!rx_en) begin
      active_d  = 1'b0;
      idx_d     = 1'b0;
      cnt_d     = '0;
      sh_d      = '0;
      fs_prev_d = 1'b0;
      err_d     = 1'b0;
    end else if (bit_stb) begin
      fs_prev_d = fs_lvl;
      if (restart) begin
        err_d    = err_q | active_q;
        active_d = 1'b1;
        idx_d    = 1'b0;
        cnt_d    = '0;
        sh_d     = '0;
      end
      if (take) begin
        if (base_cnt == wbits - 1'b1) begin
          word_d = new_sh;
          rdy_d  = 1'b1;
          sh_d   = '0;
          cnt_d  = '0;
          if (cfg_two_words && !(idx_q && !restart)) idx_d = 1'b1;
          else                                      active_d = 1'b0;
        end else begin
          sh_d  = new_sh;
          cnt_d = base_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q  <= 1'b0;
      idx_q     <= 1'b0;
      cnt_q     <= '0;
      sh_q      <= '0;
      fs_prev_q <= 1'b0;
      word_q    <= '0;
      rdy_q     <= 1'b0;
      err_q     <= 1'b0;
    end else begin
      active_q  <= active_d;
      idx_q     <= idx_d;
      cnt_q     <= cnt_d;
      sh_q      <= sh_d;
      fs_prev_q <= fs_prev_d;
      word_q    <= word_d;
      rdy_q     <= rdy_d;
      err_q     <= err_d;
    end
  end

  assign rx_word  = word_q;
  assign rx_ready = rdy_q;
  assign sync_err = err_q;

  // Checks
  logic [DATA_W-1:0] chk_mask;
  assign chk_mask = ~({DATA_W{1'b1}} << wbits);

  p_ready_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |=> !rx_ready);

  p_word_width_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ready |-> ((rx_word & ~chk_mask) == '0));

  p_count_bound_r1: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (cnt_q < wbits));

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_err && rx_en) |=> sync_err);

  p_quiet_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_en |=> (!rx_ready && !sync_err && $stable(rx_word)));
endmodule

// File: rtl/srx_receiver.sv
module srx_receiver
  import srx_pkg::*;
#(
  parameter int DATA_W      = SRX_MAX_BITS,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_en,
  input  logic              ser_clk,
  input  logic              ser_fs,
  input  logic              ser_dat,
  input  logic [2:0]        cfg_wlen,
  input  logic              cfg_two_words,
  input  logic              cfg_delay,
  input  logic              cfg_rise_edge,
  input  logic              cfg_fs_low,
  input  logic              cfg_ign_fs,
  output logic [DATA_W-1:0] rx_word,
  output logic              rx_ready,
  output logic              sync_err
);
  logic bit_stb, fs_lvl, dat_bit;

  srx_sampler #(.STAGES(SYNC_STAGES)) u_sampler (
    .clk           (clk),
    .rst_n         (rst_n),
    .ser_clk       (ser_clk),
    .ser_fs        (ser_fs),
    .ser_dat       (ser_dat),
    .cfg_rise_edge (cfg_rise_edge),
    .cfg_fs_low    (cfg_fs_low),
    .bit_stb       (bit_stb),
    .fs_lvl        (fs_lvl),
    .dat_bit       (dat_bit)
  );

  srx_shifter #(.DATA_W(DATA_W)) u_shifter (
    .clk           (clk),
    .rst_n         (rst_n),
    .rx_en         (rx_en),
    .bit_stb       (bit_stb),
    .fs_lvl        (fs_lvl),
    .dat_bit       (dat_bit),
    .cfg_wlen      (cfg_wlen),
    .cfg_two_words (cfg_two_words),
    .cfg_delay     (cfg_delay),
    .cfg_ign_fs    (cfg_ign_fs),
    .rx_word       (rx_word),
    .rx_ready      (rx_ready),
    .sync_err      (sync_err)
  );
endmodule

// File: tb/srx_receiver_tb.sv
module srx_receiver_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_en = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_fs = 1'b0;
  logic        ser_dat = 1'b0;
  logic [2:0]  cfg_wlen = 3'd2;
  logic        cfg_two_words = 1'b0;
  logic        cfg_delay = 1'b0;
  logic        cfg_rise_edge = 1'b1;
  logic        cfg_fs_low = 1'b0;
  logic        cfg_ign_fs = 1'b0;
  logic [31:0] rx_word;
  logic        rx_ready;
  logic        sync_err;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;
  logic [31:0] got_q[$];

  always #5 clk = ~clk;

  srx_receiver dut_i (
    .clk(clk), .rst_n(rst_n), .rx_en(rx_en),
    .ser_clk(ser_clk), .ser_fs(ser_fs), .ser_dat(ser_dat),
    .cfg_wlen(cfg_wlen), .cfg_two_words(cfg_two_words), .cfg_delay(cfg_delay),
    .cfg_rise_edge(cfg_rise_edge), .cfg_fs_low(cfg_fs_low), .cfg_ign_fs(cfg_ign_fs),
    .rx_word(rx_word), .rx_ready(rx_ready), .sync_err(sync_err)
  );

  always @(negedge clk) if (rst_n && rx_ready) got_q.push_back(rx_word);

  function automatic int wbits(input logic [2:0] c);
    case (c)
      3'd0: return 8;  3'd1: return 12; 3'd2: return 16;
      3'd3: return 20; 3'd4: return 24; default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] wmask(input int nb);
    return (nb >= 32) ? 32'hFFFF_FFFF : ((32'h1 << nb) - 1);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One bit-clock slot: launch edge, set lines, then sampling edge.
  task automatic slot(input bit fs_act, input bit d);
    @(negedge clk);
    ser_clk = ~cfg_rise_edge;
    ser_fs  = fs_act ^ cfg_fs_low;
    ser_dat = d;
    repeat (4) @(negedge clk);
    ser_clk = cfg_rise_edge;
    repeat (4) @(negedge clk);
  endtask

  task automatic send(input logic [31:0] w0, input logic [31:0] w1, input int extra_fs, input int limit);
    int nb    = wbits(cfg_wlen);
    int total = int'(cfg_delay) + nb * (cfg_two_words ? 2 : 1);
    for (int i = 0; i < total && (limit < 0 || i < limit); i++) begin
      int j = i - int'(cfg_delay);
      bit d;
      if (j < 0)       d = 1'b0;
      else if (j < nb) d = w0[nb-1-j];
      else             d = w1[nb-1-(j-nb)];
      slot(i == 0 || i == extra_fs, d);
    end
    if (limit < 0) begin
      slot(1'b0, 1'b0);
      slot(1'b0, 1'b0);
    end
  endtask

  task automatic setup(input logic [2:0] wl, input bit two, input bit dly, input bit rise,
                       input bit fslow, input bit ign);
    @(negedge clk);
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    cfg_wlen = wl; cfg_two_words = two; cfg_delay = dly;
    cfg_rise_edge = rise; cfg_fs_low = fslow; cfg_ign_fs = ign;
    ser_clk = ~rise; ser_fs = fslow; ser_dat = 1'b0;
    repeat (6) @(negedge clk);
    rx_en = 1'b1;
    repeat (4) @(negedge clk);
    got_q.delete();
  endtask

  task automatic expect_words(input int n, input logic [31:0] e0, input logic [31:0] e1, input string req);
    repeat (6) @(negedge clk);
    chk(got_q.size() == n, {req, " word count"}, got_q.size(), n);
    if (got_q.size() >= 1 && n >= 1) chk(got_q[0] === e0, {req, " first word"}, got_q[0], e0);
    if (got_q.size() >= 2 && n >= 2) chk(got_q[1] === e1, {req, " second word"}, got_q[1], e1);
    got_q.delete();
  endtask

  initial begin
    #1_500_000;
    if (!finished) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(rx_word == 32'h0, "R10 rx_word", rx_word, 0);
    chk(rx_ready == 1'b0, "R10 rx_ready", rx_ready, 0);
    chk(sync_err == 1'b0, "R10 sync_err", sync_err, 0);
    rst_n = 1'b1;

    // R3: both delays, 16-bit words
    setup(3'd2, 0, 0, 1, 0, 0);
    send(32'h0000A5C3, 0, -1, -1);
    expect_words(1, 32'hA5C3, 0, "R3 delay0");
    setup(3'd2, 0, 1, 1, 0, 0);
    send(32'h00003C5A, 0, -1, -1);
    expect_words(1, 32'h3C5A, 0, "R3 delay1");

    // R4: falling-edge sampling
    setup(3'd1, 0, 1, 0, 0, 0);
    send(32'h00000B6D, 0, -1, -1);
    expect_words(1, 32'h0B6D, 0, "R4 falling edge");

    // R5: active-low frame sync
    setup(3'd0, 0, 0, 1, 1, 0);
    send(32'h00000096, 0, -1, -1);
    expect_words(1, 32'h96, 0, "R5 active low");

    // R6: two-word frame, R2 one ready per word
    setup(3'd3, 1, 1, 1, 0, 0);
    send(32'h000F1234, 32'h000A9876, -1, -1);
    expect_words(2, 32'hF1234, 32'hA9876, "R6 two words R2");

    // R1: every length code, upper bits set beyond the length
    for (int c = 0; c < 8; c++) begin
      logic [31:0] w = 32'hFFFF_0000 | $urandom();
      setup(3'(c), 0, 0, 1, 0, 0);
      send(w, 0, -1, -1);
      expect_words(1, w & wmask(wbits(3'(c))), 0, "R1 length code");
    end

    // R7: mid-frame sync ignored
    setup(3'd2, 1, 1, 1, 0, 1);
    send(32'h0000BEEF, 32'h0000CAFE, 7, -1);
    expect_words(2, 32'hBEEF, 32'hCAFE, "R7 ignore");
    chk(sync_err == 1'b0, "R7 no error", sync_err, 0);

    // R8: mid-frame sync restarts and flags
    setup(3'd2, 0, 0, 1, 0, 0);
    chk(sync_err == 1'b0, "R8 clear before", sync_err, 0);
    send(32'h0000FFFF, 0, -1, 6);
    send(32'h00001357, 0, -1, -1);
    expect_words(1, 32'h1357, 0, "R8 restart");
    chk(sync_err == 1'b1, "R8 error set", sync_err, 1);

    // R9: disabled receiver ignores traffic, error cleared
    @(negedge clk);
    rx_en = 1'b0;
    repeat (3) @(negedge clk);
    chk(sync_err == 1'b0, "R9 error cleared", sync_err, 0);
    held = rx_word;
    got_q.delete();
    send(32'h00002468, 0, -1, -1);
    expect_words(0, 0, 0, "R9 disabled");
    chk(rx_word == held, "R9 word held", rx_word, held);

    // Random frames
    for (int k = 0; k < 40; k++) begin
      logic [2:0]  wl = 3'($urandom_range(0, 5));
      bit two = 1'($urandom());
      logic [31:0] a = $urandom();
      logic [31:0] b = $urandom();
      int nb = wbits(wl);
      setup(wl, two, 1'($urandom()), 1'($urandom()), 1'($urandom()), 1'($urandom()));
      send(a, b, -1, -1);
      expect_words(two ? 2 : 1, a & wmask(nb), b & wmask(nb), "R1 R4 R5 R6 random");
    end

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule